// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is a counter that runs up and down between zero and a programmable ceiling and drives two pulse-width-modulated outputs that stay centred in each period. The counter moves only on cycles where the tick enable is high. Each period it climbs from zero to the ceiling, stays at the ceiling for one tick, and then falls back to zero. The ceiling comes from the mode field. It is either one of three fixed all-ones values, the capture register, or the active copy of compare channel A.

Software writes the configuration, the two compare buffers and the capture register through one write port. Compare values go to a buffer first. The active copies take the buffered values when the counter reaches the ceiling, so a new duty cycle or ceiling takes effect only at a period boundary. Four sticky flags report reaching zero, a match on each channel, and reaching a capture-defined ceiling. Each output can be forced low, follow the non-inverted waveform, or follow the inverted waveform.

Top module: `pwm_dual_timer`

## Requirements
- R1: The mode field `cfg[3:0]` (write select 0) sets the ceiling. Mode 1 gives 0x00FF, mode 2 gives 0x01FF, mode 3 gives 0x03FF, mode 10 uses the capture register (write select 3), and mode 11 uses the active compare-A value. In any other mode the counter holds its value and the active compares follow their buffers one cycle later.
- R2: In a running mode the counter changes only on a cycle with `tick` high. It moves 0,1,…,TOP,TOP-1,…,1,0,1,… and shows TOP for exactly one tick.
- R3: A tick taken while the counter is 0 and counting down sets flag bit 0. The first tick after reset, which starts at 0 counting up, does not set it.
- R4: A write to select 1 (channel A) or select 2 (channel B) only updates that channel's buffer. In a running mode the active copy loads from the buffer on the tick taken at TOP.
- R5: The tick taken at TOP sets flag bit 3 in mode 10 and flag bit 1 in mode 11. This is the same tick that loads the buffers.
- R6: A tick taken while the counter equals a channel's active compare value sets that channel's match flag (bit 1 for A, bit 2 for B). If the compare value is above TOP, the flag is never set.
- R7: In modes 1, 2 and 3, the bits of a written compare value above the 8, 9 or 10 low bits are forced to zero as the buffer is written.
- R8: The output modes are in `cfg[5:4]` for channel A and `cfg[7:6]` for channel B. Value 2 is non-inverted: the output goes low on an up-counting match and high on a down-counting match. Value 3 is the inverse of value 2. Values 0 and 1 drive the output low.
- R9: Flags are sticky. A 1 in bit i of `flag_clr` clears flag i. A set in the same cycle takes priority over the clear.
- R10: After reset the counter is 0 and counts up. The configuration, buffers, active compares, capture register and flags are all zero, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 config, 1 compare A, 2 compare B, 3 capture |
| wr_data | input | 16 | Write data |
| flag_clr | input | 4 | Write-one-to-clear per flag |
| cnt | output | 16 | Current counter value |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |
| flags | output | 4 | Sticky flags: 0 bottom, 1 match A, 2 match B, 3 capture ceiling |

## Verification
The counter, flags and output levels are all registered. Each one changes one clock after the tick or write that caused it, so a counter value sampled at tick k reflects the state before that tick. A register write becomes visible on the outputs one cycle after its edge. Loading a new ceiling takes effect one period later, when the counter next reaches TOP. The driver pushes every expected value tagged with the cycle after the edge it drives. The monitor compares it at the falling edge of that cycle, so each prediction is checked in exactly the cycle its result is due.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

    localparam int TMR_W = 16;
    localparam int NCH   = 2;
    localparam int NFLAG = 4;

    localparam int FLG_BOT = 0;
    localparam int FLG_MA  = 1;
    localparam int FLG_MB  = 2;
    localparam int FLG_CAP = 3;

    localparam logic [3:0] MODE_FIX8   = 4'd1;
    localparam logic [3:0] MODE_FIX9   = 4'd2;
    localparam logic [3:0] MODE_FIX10  = 4'd3;
    localparam logic [3:0] MODE_CAPTOP = 4'd10;
    localparam logic [3:0] MODE_CMPTOP = 4'd11;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_CMPA = 2'd1,
        SEL_CMPB = 2'd2,
        SEL_CAP  = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_RSVD   = 2'd1,
        OUT_NONINV = 2'd2,
        OUT_INV    = 2'd3
    } out_mode_e;

    typedef struct packed {
        out_mode_e  out_b;
        out_mode_e  out_a;
        logic [3:0] mode;
    } cfg_t;

    // Number of live bits in a fixed-ceiling mode, 0 when the mode is not fixed.
    function automatic int fixed_bits(logic [3:0] m);
        case (m)
            MODE_FIX8:  return 8;
            MODE_FIX9:  return 9;
            MODE_FIX10: return 10;
            default:    return 0;
        endcase
    endfunction

    function automatic logic mode_runs(logic [3:0] m);
        return (fixed_bits(m) != 0) || (m == MODE_CAPTOP) || (m == MODE_CMPTOP);
    endfunction

endpackage

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
    import pwm_dual_pkg::*;
#(
    parameter int W   = TMR_W,
    parameter int NC  = NCH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [W-1:0]          wr_data,
    input  logic                  load_act,
    output cfg_t                  cfg,
    output logic [W-1:0]          cap_val,
    output logic [W-1:0]          fix_mask,
    output logic [NC-1:0][W-1:0]  cmp_act
);
    localparam int CFG_W = $bits(cfg_t);

    wr_sel_e sel;
    int      fb;

    always_comb begin
        sel = wr_sel_e'(wr_sel);
        fb  = fixed_bits(cfg.mode);
        if (fb == 0) fix_mask = '1;
        else         fix_mask = W'((64'd1 << fb) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            cap_val <= '0;
        end else if (wr_en) begin
            if (sel == SEL_CFG) cfg     <= cfg_t'(wr_data[CFG_W-1:0]);
            if (sel == SEL_CAP) cap_val <= wr_data;
        end
    end

    generate
        for (genvar c = 0; c < NC; c++) begin : g_buf
            logic [W-1:0] buf_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    buf_q      <= '0;
                    cmp_act[c] <= '0;
                end else begin
                    if (wr_en && (wr_sel == 2'(c + 1))) buf_q <= wr_data & fix_mask;
                    if (load_act) cmp_act[c] <= buf_q;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pwm_dual_counter.sv
module pwm_dual_counter
    import pwm_dual_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         up,
    output logic         at_top
);
    always_comb at_top = up && (cnt >= top);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (adv) begin
            if (up) begin
                if (at_top) begin
                    up  <= 1'b0;
                    cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == '0) begin
                    up  <= 1'b1;
                    cnt <= W'(1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_dual_chan.sv
module pwm_dual_chan
    import pwm_dual_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         up,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [1:0]   omode,
    output logic         match,
    output logic         pin
);
    logic level_q;

    always_comb match = adv && (cnt == cmp);

    // level_q holds the non-inverted waveform
    always_ff @(posedge clk) begin
        if (rst)        level_q <= 1'b0;
        else if (match) level_q <= ~up;
    end

    always_comb begin
        case (out_mode_e'(omode))
            OUT_NONINV: pin = level_q;
            OUT_INV:    pin = ~level_q;
            default:    pin = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
    import pwm_dual_pkg::*;
#(
    parameter int W  = TMR_W,
    parameter int NF = NFLAG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [NF-1:0] flag_clr,
    output logic [W-1:0]  cnt,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic [NF-1:0] flags
);
    localparam int NC = NCH;

    cfg_t                 cfg;
    logic [W-1:0]         cap_val;
    logic [W-1:0]         fix_mask;
    logic [NC-1:0][W-1:0] cmp_act;
    logic [NC-1:0][1:0]   omode;
    logic [NC-1:0]        match;
    logic [NC-1:0]        pins;
    logic [W-1:0]         top_val;
    logic                 run;
    logic                 adv;
    logic                 dir_up;
    logic                 at_top;
    logic                 load_act;
    logic [NF-1:0]        flag_set;

    always_comb begin
        run = mode_runs(cfg.mode);
        case (cfg.mode)
            MODE_CAPTOP: top_val = cap_val;
            MODE_CMPTOP: top_val = cmp_act[0];
            default:     top_val = fix_mask;
        endcase
        adv      = tick && run;
        load_act = !run || (adv && at_top);
        omode[0] = cfg.out_a;
        omode[1] = cfg.out_b;
    end

    pwm_dual_regs #(.W(W), .NC(NC)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .load_act(load_act), .cfg(cfg), .cap_val(cap_val), .fix_mask(fix_mask),
        .cmp_act(cmp_act)
    );

    pwm_dual_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .adv(adv), .top(top_val),
        .cnt(cnt), .up(dir_up), .at_top(at_top)
    );

    generate
        for (genvar c = 0; c < NC; c++) begin : g_ch
            pwm_dual_chan #(.W(W)) u_ch (
                .clk(clk), .rst(rst), .adv(adv), .up(dir_up), .cnt(cnt),
                .cmp(cmp_act[c]), .omode(omode[c]), .match(match[c]), .pin(pins[c])
            );
        end
    endgenerate

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_BOT] = adv && !dir_up && (cnt == '0);
        flag_set[FLG_MA]  = match[0] || (adv && at_top && (cfg.mode == MODE_CMPTOP));
        flag_set[FLG_MB]  = match[1];
        flag_set[FLG_CAP] = adv && at_top && (cfg.mode == MODE_CAPTOP);
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~flag_clr) | flag_set;
    end

    assign pwm_a = pins[0];
    assign pwm_b = pins[1];

endmodule

// File: rtl/pwm_dual_timer_chk.sv
module pwm_dual_timer_chk
    import pwm_dual_pkg::*;
#(
    parameter int W  = TMR_W,
    parameter int NF = NFLAG
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          run,
    input logic          up,
    input logic [W-1:0]  cnt,
    input logic [W-1:0]  top,
    input logic [W-1:0]  cmp_a,
    input logic [1:0]    omode_a,
    input logic          pwm_a,
    input logic [NF-1:0] flags,
    input logic [NF-1:0] flag_clr
);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    p_climb_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && run && up && (cnt < top)) |=> (cnt == $past(cnt) + 1'b1));

    p_turn_bottom_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && run && !up && (cnt == '0)) |=> (up && (cnt == W'(1))));

    p_bottom_flag_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FLG_BOT]) |-> (up && (cnt == W'(1)) && $past(tick)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (flags != '0) |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == '0));

    p_up_match_low_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && run && up && (cnt == cmp_a) && (omode_a == 2'd2)) |=>
        ((omode_a != 2'd2) || !pwm_a));

endmodule

bind pwm_dual_timer pwm_dual_timer_chk #(.W(W), .NF(NF)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .up(dir_up), .cnt(cnt),
    .top(top_val), .cmp_a(cmp_act[0]), .omode_a(omode[0]), .pwm_a(pwm_a),
    .flags(flags), .flag_clr(flag_clr)
);

// File: tb/pwm_dual_timer_bench.sv
module pwm_dual_timer_bench;

    typedef struct {
        int          due;
        int          sel;
        logic [15:0] exp;
        logic [15:0] msk;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic [3:0]  flag_clr = '0;
    logic [15:0] cnt;
    logic        pwm_a;
    logic        pwm_b;
    logic [3:0]  flags;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    item_t sb[$];

    pwm_dual_timer u_pwm_dual_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .flag_clr(flag_clr), .cnt(cnt), .pwm_a(pwm_a),
        .pwm_b(pwm_b), .flags(flags)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] observe(int sel);
        case (sel)
            0:       return cnt;
            1:       return {15'd0, pwm_a};
            2:       return {15'd0, pwm_b};
            default: return {12'd0, flags};
        endcase
    endfunction

    // monitor: compares every item due in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [15:0] got;
            it  = sb.pop_front();
            got = observe(it.sel) & it.msk;
            n_cmp++;
            if (got !== (it.exp & it.msk)) begin
                n_bad++;
                $display("FAIL %s sel=%0d cycle=%0d actual=%h expected=%h",
                         it.req, it.sel, cyc, got, it.exp & it.msk);
            end
        end
    end

    task automatic expect_nx(int sel, logic [15:0] exp, logic [15:0] msk, string req);
        item_t it;
        it.due = cyc + 1; it.sel = sel; it.exp = exp; it.msk = msk; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en    = 1'b0;
        flag_clr = '0;
    endtask

    task automatic write_reg(logic [1:0] s, logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    function automatic int tri_wave(int k, int t);
        int m;
        m = k % (2 * t);
        return (m <= t) ? m : 2 * t - m;
    endfunction

    function automatic int seq_cmptop(int k);
        if (k <= 4)  return k;
        if (k <= 8)  return 8 - k;
        if (k <= 15) return k - 8;
        return 22 - k;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R10 reset state
        expect_nx(0, 16'h0000, 16'hFFFF, "R10");
        expect_nx(3, 16'h0000, 16'h000F, "R10");
        expect_nx(1, 16'h0000, 16'h0001, "R10");
        expect_nx(2, 16'h0000, 16'h0001, "R10");
        step();

        // Capture ceiling 6, compare A 9 (above ceiling), compare B 2, B non-inverted
        write_reg(2'd3, 16'd6);
        write_reg(2'd1, 16'd9);
        write_reg(2'd2, 16'd2);
        write_reg(2'd0, 16'h008A);
        tick = 1'b1;
        for (int k = 1; k <= 30; k++) begin
            int m;
            m = k % 12;
            expect_nx(0, 16'(tri_wave(k, 6)), 16'hFFFF, "R2_R1");
            expect_nx(2, {15'd0, (k >= 11) && (m == 11 || m <= 2)}, 16'h0001, "R8");
            // bit3 capture ceiling R5, bit2 match R6, bit1 never R6, bit0 bottom R3
            expect_nx(3, {12'd0, k >= 7, k >= 3, 1'b0, k >= 13}, 16'h000F, "R3_R5_R6");
            step();
        end
        tick = 1'b0;

        // R9 clear all flags; R2 counter holds without tick
        flag_clr = 4'hF;
        expect_nx(3, 16'h0000, 16'h000F, "R9");
        expect_nx(0, 16'd6, 16'hFFFF, "R2");
        step();

        // R8 inverted then disconnected
        expect_nx(2, 16'h0001, 16'h0001, "R8");
        write_reg(2'd0, 16'h00CA);
        expect_nx(2, 16'h0000, 16'h0001, "R8");
        expect_nx(0, 16'd6, 16'hFFFF, "R2");
        write_reg(2'd0, 16'h000A);

        // Compare-A ceiling with a mid-period buffer update
        do_reset();
        write_reg(2'd1, 16'd4);
        write_reg(2'd0, 16'h000B);
        tick = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            if (k == 2) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd7;
            end
            if (k == 5) flag_clr = 4'b0010; // R9 set wins over clear
            expect_nx(0, 16'(seq_cmptop(k)), 16'hFFFF, "R4_R1");
            expect_nx(3, {12'd0, 2'b00, k >= 5, k >= 9}, 16'h0003, "R5_R9_R3");
            step();
        end
        tick = 1'b0;

        // Fixed 8-bit ceiling with an over-wide compare write
        do_reset();
        write_reg(2'd0, 16'h0001);
        write_reg(2'd1, 16'h1234);
        tick = 1'b1;
        step();
        tick = 1'b0;
        flag_clr = 4'hF;
        expect_nx(3, 16'h0000, 16'h000F, "R9");
        step();
        tick = 1'b1;
        for (int j = 2; j <= 460; j++) begin
            expect_nx(0, 16'(tri_wave(j, 255)), 16'hFFFF, "R1_R2");
            expect_nx(3, {14'd0, j >= 459, 1'b0}, 16'h0002, "R7_R4");
            step();
        end
        tick = 1'b0;
        step();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule